// File: doc/BRIEF.md
# Alternating Dual-Register Block Store Buffer

This block connects a byte-wide serial-bus slave to the wide data port of a memory array that stores data in 64-bit blocks, 32 blocks to a page. A write session begins with a start pulse that names a page. Incoming bytes are then collected into one of two 64-bit registers. Once eight bytes have been gathered, that register is handed to the array for a parallel write. The other register takes the next bytes in the meantime. If a byte arrives while neither register can take it, the acknowledge for that byte is held back until an array write completes.

A read session runs the same path the other way. The array loads blocks into whichever register is free, and the host drains the loaded register one byte at a time while the other register is refilled in the background. A stop pulse ends a session. In write mode, a register that is only partly filled at the stop is either zero-padded and written or thrown away, as chosen by a configuration input.

Top module: `pp_blk_buf`

## Requirements
- R1: After reset, wr_ack_o, arr_req_o and rd_valid_o are all 0.
- R2: In write mode, the first byte acknowledged after a block boundary lands in bits 63:56 of the stored word, and the eighth lands in bits 7:0. An array write (arr_req_o=1, arr_we_o=1) carries that word on arr_wdata_o.
- R3: While one register is being written to the array, bytes keep being acknowledged into the other register. With an array latency of two cycles or less, a continuous byte stream is never stalled.
- R4: wr_ack_o stays 0 while the register due to receive the next byte still holds an unwritten or in-flight block, and no byte is lost. wr_ack_o is never 1 without wr_valid_i.
- R5: arr_req_o is a single-cycle pulse. Only one array access is outstanding at a time, and a register is released only when arr_done_i arrives.
- R6: arr_addr_o is {page[10:0], block[4:0]}. An accepted start loads {start_page_i, 0}, and each completed access advances the address by one block. Block 31 is followed by block 0 of the next page, and the last page (PAGES-1) wraps to page 0.
- R7: A stop in write mode with pad_en_i=1 and 1 to 7 bytes pending writes one block. The pending bytes sit at the top in arrival order and the remaining bytes are 0x00.
- R8: A stop in write mode with pad_en_i=0 drops the pending bytes and issues no array access. The next eight bytes form a clean block at the next address.
- R9: Start with mode_rd_i=1 makes the block fetch blocks from the array (arr_we_o=0) in address order. Their bytes appear on rd_byte_o most significant byte first, and each is taken when rd_valid_o and rd_ready_i are both 1. An untaken byte holds steady.
- R10: A stop in read mode drops rd_valid_o on the following cycle and discards prefetched data. An access still in flight completes without reloading a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Session start pulse (taken only when the array side is idle) |
| mode_rd_i | input | 1 | Session direction sampled at start: 1 read, 0 write |
| start_page_i | input | 11 | Page loaded at start |
| stop_i | input | 1 | Session stop pulse |
| pad_en_i | input | 1 | On a write stop: 1 pad partial block, 0 discard it |
| wr_valid_i | input | 1 | Host offers a byte |
| wr_byte_i | input | 8 | Offered byte |
| wr_ack_o | output | 1 | Byte accepted at this clock edge |
| rd_ready_i | input | 1 | Host takes a byte |
| rd_valid_o | output | 1 | Read byte available |
| rd_byte_o | output | 8 | Read byte |
| arr_req_o | output | 1 | Array access request, one cycle |
| arr_we_o | output | 1 | 1 write, 0 read |
| arr_addr_o | output | 16 | {page, block} of the access |
| arr_wdata_o | output | 64 | Block to write, held until done |
| arr_done_i | input | 1 | Array access complete |
| arr_rdata_i | input | 64 | Block read, valid with arr_done_i |

## Verification
The hardest state to reach is the one where both registers are occupied at once: one is in flight to the array and the other is full and waiting, so the next byte must be refused. The bench reaches it by stretching the array model's latency to twenty cycles while streaming bytes back to back. It then counts the cycles in which a byte was offered but refused, and checks that the three stored words are intact. Page rollover and the wrap from the last page are reached by writing 33 consecutive blocks from a chosen start page.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY,
    SLOT_FILL,
    SLOT_FULL,
    SLOT_BUSY
  } slot_st_e;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_PUSH,
    OP_PAD,
    OP_CLR,
    OP_ISSUE,
    OP_RETIRE,
    OP_LOAD,
    OP_POP
  } slot_op_e;
endpackage

// File: rtl/pp_slot.sv
module pp_slot
  import ppbuf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  slot_op_e          op_i,
  input  logic              last_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [CNT_W:0]    pad_sh_i,
  input  logic [DATA_W-1:0] word_i,
  output slot_st_e          state_o,
  output logic [DATA_W-1:0] word_o
);
  slot_st_e          st_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SLOT_EMPTY;
      word_q <= '0;
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          word_q <= {word_q[DATA_W-BYTE_W-1:0], byte_i};
          st_q   <= last_i ? SLOT_FULL : SLOT_FILL;
        end
        OP_PAD: begin
          // left-align pending bytes, zero fill below
          word_q <= word_q << (BYTE_W * int'(pad_sh_i));
          st_q   <= SLOT_FULL;
        end
        OP_CLR: begin
          word_q <= '0;
          st_q   <= SLOT_EMPTY;
        end
        OP_ISSUE:  st_q <= SLOT_BUSY;
        OP_RETIRE: st_q <= SLOT_EMPTY;
        OP_LOAD: begin
          word_q <= word_i;
          st_q   <= SLOT_FULL;
        end
        OP_POP: begin
          word_q <= word_q << BYTE_W;
          st_q   <= last_i ? SLOT_EMPTY : SLOT_FULL;
        end
        default: ;
      endcase
    end
  end

  assign state_o = st_q;
  assign word_o  = word_q;
endmodule

// File: rtl/pp_addr_ctr.sv
module pp_addr_ctr #(
  parameter int PAGE_W = 11,
  parameter int BLK_W  = 5,
  parameter int PAGES  = 1888,
  parameter int BLKS   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              inc_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [BLK_W-1:0]  blk_o
);
  localparam logic [PAGE_W-1:0] PAGE_LAST = PAGE_W'(PAGES - 1);
  localparam logic [BLK_W-1:0]  BLK_LAST  = BLK_W'(BLKS - 1);

  logic [PAGE_W-1:0] page_q;
  logic [BLK_W-1:0]  blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      blk_q  <= '0;
    end else if (load_i) begin
      page_q <= page_i;
      blk_q  <= '0;
    end else if (inc_i) begin
      if (blk_q == BLK_LAST) begin
        blk_q  <= '0;
        page_q <= (page_q == PAGE_LAST) ? '0 : page_q + 1'b1;
      end else begin
        blk_q <= blk_q + 1'b1;
      end
    end
  end

  assign page_o = page_q;
  assign blk_o  = blk_q;
endmodule

// File: rtl/pp_blk_buf.sv
module pp_blk_buf
  import ppbuf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 11,
  parameter int BLKS   = 32,
  parameter int PAGES  = 1888,
  localparam int BYTES  = DATA_W / BYTE_W,
  localparam int CNT_W  = $clog2(BYTES),
  localparam int BLK_W  = $clog2(BLKS),
  localparam int ADDR_W = PAGE_W + BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_rd_i,
  input  logic [PAGE_W-1:0] start_page_i,
  input  logic              stop_i,
  input  logic              pad_en_i,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output logic              wr_ack_o,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              arr_req_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  input  logic              arr_done_i,
  input  logic [DATA_W-1:0] arr_rdata_i
);
  localparam int NSLOT = 2;

  slot_st_e          st   [NSLOT];
  slot_op_e          op   [NSLOT];
  logic [DATA_W-1:0] word [NSLOT];

  logic              mode_q, active_q, busy_q, req_q, we_q;
  logic              fill_sel_q, arb_sel_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] cur_page;
  logic [BLK_W-1:0]  cur_blk;

  logic start_ok, fill_open, wr_ack, rd_valid, pop, issue, done, cnt_last;
  logic any_full, wr_stop, rd_stop, partial;
  logic [CNT_W:0] pad_sh;

  assign any_full  = (st[0] == SLOT_FULL) || (st[1] == SLOT_FULL);
  assign start_ok  = start_i && !busy_q && !(!mode_q && any_full);
  assign fill_open = (st[fill_sel_q] == SLOT_EMPTY) || (st[fill_sel_q] == SLOT_FILL);
  assign wr_ack    = wr_valid_i && !mode_q && !stop_i && !start_i && fill_open;
  assign rd_valid  = mode_q && (st[fill_sel_q] == SLOT_FULL);
  assign pop       = rd_valid && rd_ready_i && !stop_i && !start_i;
  assign done      = busy_q && arr_done_i;
  assign issue     = !busy_q && !stop_i && !start_i &&
                     (mode_q ? (active_q && st[arb_sel_q] == SLOT_EMPTY)
                             : (st[arb_sel_q] == SLOT_FULL));
  assign cnt_last  = (cnt_q == CNT_W'(BYTES - 1));
  assign wr_stop   = !mode_q && stop_i && !start_i;
  assign rd_stop   = mode_q && stop_i && !start_i;
  assign partial   = (cnt_q != '0);
  assign pad_sh    = (CNT_W+1)'(BYTES) - {1'b0, cnt_q};

  // per-slot operation select; priority order avoids overlap between roles
  always_comb begin
    for (int g = 0; g < NSLOT; g++) begin
      op[g] = OP_NOP;
      if (start_ok) begin
        op[g] = OP_CLR;
      end else if (done && (arb_sel_q == 1'(g))) begin
        op[g] = (mode_q && active_q && !stop_i) ? OP_LOAD : OP_RETIRE;
      end else if (issue && (arb_sel_q == 1'(g))) begin
        op[g] = OP_ISSUE;
      end else if (rd_stop && (st[g] == SLOT_FULL)) begin
        op[g] = OP_CLR;
      end else if (fill_sel_q == 1'(g)) begin
        if (wr_ack)                     op[g] = OP_PUSH;
        else if (pop)                   op[g] = OP_POP;
        else if (wr_stop && partial)    op[g] = pad_en_i ? OP_PAD : OP_CLR;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    pp_slot #(
      .DATA_W(DATA_W),
      .BYTE_W(BYTE_W),
      .CNT_W (CNT_W)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op[g]),
      .last_i  (cnt_last),
      .byte_i  (wr_byte_i),
      .pad_sh_i(pad_sh),
      .word_i  (arr_rdata_i),
      .state_o (st[g]),
      .word_o  (word[g])
    );
  end

  pp_addr_ctr #(
    .PAGE_W(PAGE_W),
    .BLK_W (BLK_W),
    .PAGES (PAGES),
    .BLKS  (BLKS)
  ) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(start_ok),
    .page_i(start_page_i),
    .inc_i (done),
    .page_o(cur_page),
    .blk_o (cur_blk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= 1'b0;
      active_q   <= 1'b0;
      fill_sel_q <= 1'b0;
      cnt_q      <= '0;
    end else if (start_ok) begin
      mode_q     <= mode_rd_i;
      active_q   <= mode_rd_i;
      fill_sel_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (wr_ack || pop) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_last) fill_sel_q <= ~fill_sel_q;
      end else if (wr_stop && partial) begin
        cnt_q <= '0;
        if (pad_en_i) fill_sel_q <= ~fill_sel_q;
      end
      if (rd_stop) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      arb_sel_q <= 1'b0;
      addr_q    <= '0;
    end else begin
      req_q <= issue;
      if (start_ok) begin
        arb_sel_q <= 1'b0;
      end else if (issue) begin
        busy_q <= 1'b1;
        we_q   <= !mode_q;
        addr_q <= {cur_page, cur_blk};
      end else if (done) begin
        busy_q    <= 1'b0;
        arb_sel_q <= ~arb_sel_q;
      end
    end
  end

  assign wr_ack_o    = wr_ack;
  assign rd_valid_o  = rd_valid;
  assign rd_byte_o   = word[fill_sel_q][DATA_W-1 -: BYTE_W];
  assign arr_req_o   = req_q;
  assign arr_we_o    = we_q;
  assign arr_addr_o  = addr_q;
  assign arr_wdata_o = word[arb_sel_q];
endmodule

// File: rtl/pp_blk_buf_chk.sv
module pp_blk_buf_chk #(
  parameter int PAGE_W = 11,
  parameter int BLK_W  = 5,
  parameter int PAGES  = 1888,
  parameter int BYTE_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    stop_i,
  input logic                    wr_valid_i,
  input logic                    wr_ack_o,
  input logic                    rd_ready_i,
  input logic                    rd_valid_o,
  input logic [BYTE_W-1:0]       rd_byte_o,
  input logic                    arr_req_o,
  input logic                    arr_done_i,
  input logic [PAGE_W+BLK_W-1:0] arr_addr_o
);
  logic                    pend_q, have_last_q;
  logic [PAGE_W+BLK_W-1:0] last_q, next_addr;
  logic [PAGE_W-1:0]       lpg;
  logic [BLK_W-1:0]        lbk;

  assign lpg = last_q[PAGE_W+BLK_W-1:BLK_W];
  assign lbk = last_q[BLK_W-1:0];
  always_comb begin
    if (&lbk) next_addr = (lpg == PAGE_W'(PAGES - 1)) ? '0 : {lpg + 1'b1, {BLK_W{1'b0}}};
    else      next_addr = last_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      have_last_q <= 1'b0;
      last_q      <= '0;
    end else begin
      if (arr_req_o && !arr_done_i) pend_q <= 1'b1;
      else if (arr_done_i)          pend_q <= 1'b0;
      if (start_i) have_last_q <= 1'b0;
      else if (arr_req_o) have_last_q <= 1'b1;
      if (arr_req_o) last_q <= arr_addr_o;
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_req_o |=> !arr_req_o); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_req_o |-> !pend_q); // R5
  AST_ACK_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> wr_valid_i); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_req_o && have_last_q && !start_i) |-> (arr_addr_o == next_addr)); // R6
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i && !stop_i && !start_i) |=> (rd_valid_o && $stable(rd_byte_o))); // R9
  AST_RD_STOP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && rd_valid_o && !start_i) |=> !rd_valid_o); // R10
endmodule

bind pp_blk_buf pp_blk_buf_chk #(
  .PAGE_W(PAGE_W),
  .BLK_W (BLK_W),
  .PAGES (PAGES),
  .BYTE_W(BYTE_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .wr_valid_i(wr_valid_i),
  .wr_ack_o  (wr_ack_o),
  .rd_ready_i(rd_ready_i),
  .rd_valid_o(rd_valid_o),
  .rd_byte_o (rd_byte_o),
  .arr_req_o (arr_req_o),
  .arr_done_i(arr_done_i),
  .arr_addr_o(arr_addr_o)
);

// File: tb/pp_blk_buf_bench.sv
`timescale 1ns/1ps
module pp_blk_buf_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 0, mode_rd_i = 0, stop_i = 0, pad_en_i = 0;
  logic [10:0] start_page_i = '0;
  logic        wr_valid_i = 0, rd_ready_i = 0, arr_done_i = 0;
  logic [7:0]  wr_byte_i = '0;
  logic [63:0] arr_rdata_i = '0;
  logic        wr_ack_o, rd_valid_o, arr_req_o, arr_we_o;
  logic [7:0]  rd_byte_o;
  logic [15:0] arr_addr_o;
  logic [63:0] arr_wdata_o;

  always #2 clk_i = ~clk_i;

  pp_blk_buf u_pp_blk_buf (.*);

  int total = 0, bad = 0, stall = 0, lat = 1, n_req = 0;
  logic [15:0] log_addr [256];
  logic [63:0] log_data [256];
  logic        log_we   [256];

  localparam logic [63:0] VEC_WORD [4] = '{64'h0123_4567_89AB_CDEF, 64'hFFEE_DDCC_BBAA_9988,
                                           64'h8000_0000_0000_0001, 64'h5A5A_A5A5_0F0F_F0F0};
  localparam int VEC_LAT [4] = '{0, 1, 2, 5};

  function automatic logic [63:0] rd_fn(input logic [15:0] a);
    return {a, ~a, 16'hA5C3, a ^ 16'h1234};
  endfunction

  function automatic logic [15:0] mk_addr(input int p, input int b);
    return {11'(p), 5'(b)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // array model
  initial begin
    forever begin
      @(negedge clk_i);
      arr_done_i = 1'b0;
      if (arr_req_o) begin
        log_addr[n_req & 255] = arr_addr_o;
        log_data[n_req & 255] = arr_wdata_o;
        log_we[n_req & 255]   = arr_we_o;
        n_req++;
        repeat (lat) @(negedge clk_i);
        arr_rdata_i = rd_fn(arr_addr_o);
        arr_done_i  = 1'b1;
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk_i);
    wr_valid_i = 1'b1;
    wr_byte_i  = b;
    #0.5;
    while (!wr_ack_o) begin
      stall++;
      @(negedge clk_i);
      #0.5;
    end
    @(posedge clk_i);
    #0.5 wr_valid_i = 1'b0;
  endtask

  task automatic send_word(input logic [63:0] w);
    for (int i = 7; i >= 0; i--) send(w[i*8 +: 8]);
  endtask

  task automatic recv(output logic [7:0] b);
    @(negedge clk_i);
    rd_ready_i = 1'b1;
    while (!rd_valid_o) @(negedge clk_i);
    b = rd_byte_o;
    @(posedge clk_i);
    #0.5 rd_ready_i = 1'b0;
  endtask

  task automatic start(input bit rd, input int page);
    @(negedge clk_i);
    start_i = 1'b1; mode_rd_i = rd; start_page_i = 11'(page);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic stop(input bit pad);
    @(negedge clk_i);
    stop_i = 1'b1; pad_en_i = pad;
    @(negedge clk_i);
    stop_i = 1'b0;
  endtask

  task automatic wait_req(input int target);
    while (n_req < target) @(negedge clk_i);
    repeat (12) @(negedge clk_i);
  endtask

  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic [63:0] rw;
    logic [7:0]  b;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(wr_ack_o == 0 && arr_req_o == 0 && rd_valid_o == 0, "R1 reset outputs",
        {wr_ack_o, arr_req_o, rd_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(wr_ack_o == 0 && arr_req_o == 0 && rd_valid_o == 0, "R1 after release",
        {wr_ack_o, arr_req_o, rd_valid_o}, 0);

    // R2/R6 table walk, page 3
    start(0, 3);
    for (int k = 0; k < 4; k++) begin
      lat = VEC_LAT[k];
      base = n_req;
      send_word(VEC_WORD[k]);
      wait_req(base + 1);
      chk(log_data[base] == VEC_WORD[k] && log_we[base], "R2 word order", log_data[base], VEC_WORD[k]);
      chk(log_addr[base] == mk_addr(3, k), "R6 block address", log_addr[base], mk_addr(3, k));
    end

    // R3 no stall with short latency
    lat = 2; stall = 0; base = n_req;
    for (int k = 0; k < 3; k++) send_word(VEC_WORD[k]);
    wait_req(base + 3);
    chk(stall == 0, "R3 stream without stall", stall, 0);
    chk(log_data[base + 1] == VEC_WORD[1], "R3 alternate register data", log_data[base + 1], VEC_WORD[1]);

    // R4 backpressure with long latency
    lat = 20; stall = 0; base = n_req;
    for (int k = 0; k < 3; k++) send_word(VEC_WORD[3 - k]);
    wait_req(base + 3);
    chk(stall > 0, "R4 ack withheld", stall, 1);
    for (int k = 0; k < 3; k++)
      chk(log_data[base + k] == VEC_WORD[3 - k], "R4 no byte lost", log_data[base + k], VEC_WORD[3 - k]);
    chk(log_addr[base + 2] == mk_addr(3, 9), "R6 addr after backpressure", log_addr[base + 2], mk_addr(3, 9));

    // R7 pad
    lat = 1; base = n_req;
    send(8'h11); send(8'h22); send(8'h33);
    stop(1);
    wait_req(base + 1);
    chk(log_data[base] == 64'h1122_3300_0000_0000, "R7 padded block", log_data[base], 64'h1122_3300_0000_0000);
    chk(log_addr[base] == mk_addr(3, 10), "R7 padded address", log_addr[base], mk_addr(3, 10));

    // R8 discard
    base = n_req;
    send(8'h44); send(8'h55); send(8'h66);
    stop(0);
    repeat (30) @(negedge clk_i);
    chk(n_req == base, "R8 no access on discard", n_req, base);
    send_word(64'hC0C1_C2C3_C4C5_C6C7);
    wait_req(base + 1);
    chk(log_data[base] == 64'hC0C1_C2C3_C4C5_C6C7, "R8 clean next block", log_data[base], 64'hC0C1_C2C3_C4C5_C6C7);
    chk(log_addr[base] == mk_addr(3, 11), "R8 next address", log_addr[base], mk_addr(3, 11));

    // R6 page rollover
    lat = 0;
    start(0, 7);
    base = n_req;
    for (int k = 0; k < 33; k++) send_word({32'(k), 32'hDEAD_0000});
    wait_req(base + 33);
    chk(log_addr[(base + 31) & 255] == mk_addr(7, 31), "R6 block 31", log_addr[(base + 31) & 255], mk_addr(7, 31));
    chk(log_addr[(base + 32) & 255] == mk_addr(8, 0), "R6 next page", log_addr[(base + 32) & 255], mk_addr(8, 0));

    // R6 last-page wrap
    start(0, 1887);
    base = n_req;
    for (int k = 0; k < 33; k++) send_word({32'(k), 32'hBEEF_0000});
    wait_req(base + 33);
    chk(log_addr[(base + 32) & 255] == mk_addr(0, 0), "R6 wrap to page 0", log_addr[(base + 32) & 255], 0);

    // R9 read
    lat = 2;
    start(1, 2);
    base = n_req;
    for (int k = 0; k < 2; k++) begin
      rw = '0;
      for (int i = 0; i < 8; i++) begin
        recv(b);
        rw = {rw[55:0], b};
      end
      chk(rw == rd_fn(mk_addr(2, k)), "R9 read bytes msb first", rw, rd_fn(mk_addr(2, k)));
    end
    chk(log_we[base] == 0 && log_addr[base] == mk_addr(2, 0), "R9 read access", {log_we[base], log_addr[base]},
        {1'b0, mk_addr(2, 0)});
    repeat (10) @(negedge clk_i);
    chk(rd_valid_o == 1 && rd_byte_o == rd_fn(mk_addr(2, 2))[63:56], "R9 prefetched byte held",
        rd_byte_o, rd_fn(mk_addr(2, 2))[63:56]);

    // R10 read stop
    stop(0);
    chk(rd_valid_o == 0, "R10 valid dropped", rd_valid_o, 0);
    repeat (20) @(negedge clk_i);
    chk(rd_valid_o == 0, "R10 stays idle", rd_valid_o, 0);
    start(1, 5);
    recv(b);
    chk(b == rd_fn(mk_addr(5, 0))[63:56], "R10 restart read", b, rd_fn(mk_addr(5, 0))[63:56]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule